// File: doc/BRIEF.md
# Card Identification EEPROM Mailbox

This block gives a processor word-wide access to the identification bytes of up to three plug-in interface cards, so that software never toggles serial EEPROM pins by hand. Each card slot delivers its 64-byte EEPROM image as a flat input vector, together with a flag that says whether a card is fitted. The processor reaches the block through a small register port. Two register addresses matter. The select register picks a slot by code. The data register takes the command words and returns the result word.

A read runs in three steps. The processor writes a slot-select code. It then writes two command words to the data register. The first word carries the byte offset in its low six bits, and the second word is a placeholder. The next read of the data register returns two consecutive bytes of the selected card, packed into one 16-bit word. A result can be read once only. Empty slots, unrecognised select codes and reads made without a pending result all return all-ones.

Requests arrive on a valid/ready channel. Read data leaves on a second valid/ready channel. Only one read response can be outstanding, so `req_ready` stays low while a response waits. The response word holds steady until `rsp_ready` takes it. Writes produce no response.

Top module: `eemb_mailbox`

## Requirements
- R1: After synchronous reset, no slot is selected, the command pointer is 0, no result is pending and no response is outstanding. A read of the data register (address 0x42) therefore returns 0xFFFF.
- R2: A read of the select register (address 0x12) returns 0xFFFF with bit n (n = 0..2) cleared for each slot n whose card-present flag is 1.
- R3: A write to address 0x12 stores a select code. 0x1700 selects slot 0, 0x1D00 selects slot 1 and 0x3500 selects slot 2. Any other code selects nothing, and a result fetched under such a code is 0xFFFF.
- R4: Writes to address 0x42 are taken as command words in order. The result becomes valid only after the second word. After a single write, a data read still returns 0xFFFF.
- R5: The byte offset is the low 6 bits of the first command word, and the upper bits are ignored. The result is (byte[off] << 8) | byte[off+1], where byte k of slot s sits at bits [(s*64+k)*8 +: 8] of `card_rom`.
- R6: A data read consumes the valid result. A second read with no new command returns 0xFFFF.
- R7: If the selected slot has no card, the result read is 0xFFFF and the valid result is still consumed.
- R8: The second byte address wraps within 64 bytes, so offset 63 pairs byte 63 with byte 0.
- R9: Writing a select code resets neither the command pointer nor a pending valid result. The slot used is the one selected at the time of the read.
- R10: A read request that is accepted produces a response on the next cycle. `req_ready` is low while a response is outstanding. `rsp_rdata` holds steady while `rsp_valid` is high and `rsp_ready` is low.
- R11: A read of any other address returns 0x0000. Writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block accepts the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 16 | Read response data |
| card_present | input | 3 | Per-slot card fitted flag |
| card_rom | input | 1536 | Three 64-byte EEPROM images, slot-major, byte 0 lowest |

## Verification
A command pointer stuck at the wrong position shows up on the first data read after a command pair. That read returns 0xFFFF where card bytes were expected, or card bytes where 0xFFFF was expected. A valid flag that is never cleared shows up as a second read that repeats the card word. A wrong select decode or a wrong byte index shows up as a mismatched response word in the cycle after the read is accepted. The reference model compares `rsp_valid`, `req_ready` and `rsp_rdata` on every clock, so each such fault is reported within one cycle of the response appearing.

// File: rtl/eemb_pkg.sv
package eemb_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 16;
  localparam int ROM_BYTES = 64;
  localparam int OFF_W     = $clog2(ROM_BYTES);

  localparam logic [ADDR_W-1:0] REG_SELECT = 8'h12;
  localparam logic [ADDR_W-1:0] REG_DATA   = 8'h42;

  localparam logic [DATA_W-1:0] ALL_ONES   = '1;

  // select code recognised for each slot index
  function automatic logic [DATA_W-1:0] slot_code(input int idx);
    case (idx)
      0:       slot_code = 16'h1700;
      1:       slot_code = 16'h1D00;
      2:       slot_code = 16'h3500;
      default: slot_code = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/eemb_select_dec.sv
module eemb_select_dec
  import eemb_pkg::*;
#(
  parameter int NSLOTS = 3,
  localparam int IDX_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic [DATA_W-1:0] code,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [NSLOTS-1:0] match;

  for (genvar s = 0; s < NSLOTS; s++) begin : g_cmp
    assign match[s] = (code == slot_code(s));
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int s = 0; s < NSLOTS; s++)
      if (match[s]) idx = IDX_W'(s);
  end
endmodule

// File: rtl/eemb_cmd_seq.sv
module eemb_cmd_seq
  import eemb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [OFF_W-1:0] cmd_off,
  input  logic             take,
  output logic             ptr,
  output logic             valid,
  output logic [OFF_W-1:0] offset
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= 1'b0;
      valid  <= 1'b0;
      offset <= '0;
    end else begin
      if (take) valid <= 1'b0;
      if (cmd_wr) begin
        if (!ptr) begin
          offset <= cmd_off;
          ptr    <= 1'b1;
        end else begin
          ptr    <= 1'b0;
          valid  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/eemb_word_fetch.sv
module eemb_word_fetch
  import eemb_pkg::*;
#(
  parameter int NSLOTS = 3,
  localparam int IDX_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1,
  localparam int ROM_W = NSLOTS * ROM_BYTES * 8
) (
  input  logic [ROM_W-1:0]  rom,
  input  logic [NSLOTS-1:0] present,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  offset,
  output logic [DATA_W-1:0] word
);
  logic [OFF_W-1:0] off_next;
  logic [7:0]       hi_b, lo_b;

  assign off_next = offset + 1'b1;

  always_comb begin
    hi_b = rom[(int'(idx) * ROM_BYTES + int'(offset))   * 8 +: 8];
    lo_b = rom[(int'(idx) * ROM_BYTES + int'(off_next)) * 8 +: 8];
    if (hit && present[idx]) word = {hi_b, lo_b};
    else                     word = ALL_ONES;
  end
endmodule

// File: rtl/eemb_mailbox.sv
module eemb_mailbox
  import eemb_pkg::*;
#(
  parameter int NSLOTS = 3,
  localparam int IDX_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1,
  localparam int ROM_W = NSLOTS * ROM_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [NSLOTS-1:0] card_present,
  input  logic [ROM_W-1:0]  card_rom
);
  logic              acc, acc_rd, acc_wr;
  logic [DATA_W-1:0] sel_code;
  logic              sel_hit;
  logic [IDX_W-1:0]  sel_idx;
  logic              cmd_ptr, cmd_valid;
  logic [OFF_W-1:0]  cmd_offset;
  logic [DATA_W-1:0] fetched, rd_mux;
  logic              rsp_q;

  assign req_ready = !rsp_q;
  assign rsp_valid = rsp_q;
  assign acc    = req_valid && req_ready;
  assign acc_rd = acc && !req_write;
  assign acc_wr = acc && req_write;

  always_ff @(posedge clk) begin
    if (rst)                                    sel_code <= '0;
    else if (acc_wr && req_addr == REG_SELECT)  sel_code <= req_wdata;
  end

  eemb_select_dec #(.NSLOTS(NSLOTS)) u_dec (
    .code(sel_code), .hit(sel_hit), .idx(sel_idx)
  );

  eemb_cmd_seq u_seq (
    .clk(clk), .rst(rst),
    .cmd_wr(acc_wr && req_addr == REG_DATA),
    .cmd_off(req_wdata[OFF_W-1:0]),
    .take(acc_rd && req_addr == REG_DATA),
    .ptr(cmd_ptr), .valid(cmd_valid), .offset(cmd_offset)
  );

  eemb_word_fetch #(.NSLOTS(NSLOTS)) u_fetch (
    .rom(card_rom), .present(card_present), .hit(sel_hit),
    .idx(sel_idx), .offset(cmd_offset), .word(fetched)
  );

  always_comb begin
    rd_mux = '0;
    if (req_addr == REG_SELECT) begin
      rd_mux = ALL_ONES;
      rd_mux[NSLOTS-1:0] = ~card_present;
    end else if (req_addr == REG_DATA) begin
      rd_mux = cmd_valid ? fetched : ALL_ONES;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q     <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc_rd) begin
      rsp_q     <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_q     <= 1'b0;
    end
  end
endmodule

// File: rtl/eemb_mailbox_chk.sv
module eemb_mailbox_chk
  import eemb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              cmd_ptr,
  input logic              cmd_valid
);
  // R10
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R10
  write_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write) |=> !rsp_valid);

  // R4
  second_word_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write && req_addr == REG_DATA && cmd_ptr)
      |=> (cmd_valid && !cmd_ptr));

  // R6
  read_consumes_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write && req_addr == REG_DATA) |=> !cmd_valid);

  // R9
  select_keeps_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write && req_addr == REG_SELECT)
      |=> ($stable(cmd_ptr) && $stable(cmd_valid)));
endmodule

bind eemb_mailbox eemb_mailbox_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .cmd_ptr(cmd_ptr), .cmd_valid(cmd_valid)
);

// File: tb/tb_eemb_mailbox.sv
`timescale 1ns/1ps
module tb_eemb_mailbox;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [NS-1:0] card_present = '0;
  logic [NS*64*8-1:0] card_rom;

  always #4 clk = ~clk;

  eemb_mailbox dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .card_present(card_present), .card_rom(card_rom)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  // reference model state
  int m_sel = 0, m_ptr = 0, m_valid = 0, m_off = 0;
  int m_pend = 0, m_data = 0;

  function automatic int byte_of(int s, int k);
    return ((s * 64 + k) * 7 + 3) & 255;
  endfunction

  function automatic int slot_of(int code);
    if (code == 'h1700) return 0;
    if (code == 'h1D00) return 1;
    if (code == 'h3500) return 2;
    return -1;
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic step();
    bit a_req, a_rsp, wr;
    int addr, wd, s;
    a_req = req_valid && req_ready;
    a_rsp = rsp_valid && rsp_ready;
    wr = req_write; addr = req_addr; wd = req_wdata;
    @(posedge clk); #1;
    if (rst) begin
      m_sel = 0; m_ptr = 0; m_valid = 0; m_off = 0; m_pend = 0; m_data = 0;
    end else begin
      if (a_rsp) m_pend = 0;
      if (a_req && wr) begin
        if (addr == 'h12) m_sel = wd;
        else if (addr == 'h42) begin
          if (m_ptr == 0) begin m_off = wd & 63; m_ptr = 1; end
          else begin m_ptr = 0; m_valid = 1; end
        end
      end else if (a_req) begin
        m_pend = 1;
        if (addr == 'h12) m_data = 'hFFFF & ~int'(card_present);
        else if (addr == 'h42) begin
          s = slot_of(m_sel);
          if (m_valid && s >= 0 && card_present[s])
            m_data = (byte_of(s, m_off) << 8) | byte_of(s, (m_off + 1) % 64);
          else m_data = 'hFFFF;
          m_valid = 0;
        end else m_data = 0;
      end
    end
    chk("rsp_valid", rsp_valid, m_pend);
    chk("req_ready", req_ready, !m_pend);
    if (m_pend) chk("rsp_rdata", rsp_rdata, m_data);
  endtask

  task automatic issue(bit w, int addr, int data, int stall = 0);
    req_valid = 1; req_write = w; req_addr = 8'(addr); req_wdata = 16'(data);
    rsp_ready = (stall == 0);
    step();
    req_valid = 0;
    for (int i = 0; i < stall; i++) step();
    rsp_ready = 1;
    step();
  endtask

  task automatic wr(int a, int d); issue(1, a, d); endtask
  task automatic rd(int a, int stall = 0); issue(0, a, 0, stall); endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 64; k++)
        card_rom[(s * 64 + k) * 8 +: 8] = 8'(byte_of(s, k));
    card_present = 3'b111;
    rst = 1; step(); step(); rst = 0; step();
    cur_req = "R1"; rd('h42);
    cur_req = "R2"; rd('h12);
    card_present = 3'b010; rd('h12);
    card_present = 3'b111;
    cur_req = "R5"; wr('h12, 'h1700); wr('h42, 'h180 | 5); wr('h42, 0); rd('h42);
    cur_req = "R6"; rd('h42);
    cur_req = "R3"; wr('h12, 'h1D00); wr('h42, 'h1C0 | 17); wr('h42, 0); rd('h42);
    wr('h12, 'h3500); wr('h42, 'h180 | 40); wr('h42, 0); rd('h42);
    wr('h12, 'h1234); wr('h42, 'h180); wr('h42, 0); rd('h42);
    cur_req = "R4"; wr('h12, 'h1700); wr('h42, 'h180 | 9); rd('h42);
    wr('h42, 0); rd('h42);
    cur_req = "R8"; wr('h42, 'h180 | 63); wr('h42, 0); rd('h42);
    cur_req = "R7"; card_present = 3'b101; wr('h12, 'h1D00);
    wr('h42, 'h180 | 3); wr('h42, 0); rd('h42); rd('h42);
    card_present = 3'b111;
    cur_req = "R9"; wr('h42, 'h180 | 12); wr('h12, 'h3500); wr('h42, 0);
    wr('h12, 'h1700); rd('h42);
    cur_req = "R10"; wr('h42, 'h180 | 30); wr('h42, 0); rd('h42, 3); rd('h12, 2);
    cur_req = "R11"; rd('h30); wr('h30, 'h1D00); wr('h20, 'h55); rd('h42);
    wr('h42, 'h180 | 2); wr('h42, 0); rd('h42);
    cur_req = "R1"; wr('h42, 'h180 | 7); rst = 1; step(); rst = 0; step();
    wr('h42, 0); rd('h42);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    finish_run();
  end
endmodule